// File: doc/BRIEF.md
# Two-Way Translation Buffer with Access Protection

This block turns a 40-bit virtual byte address into a 36-bit physical address. Pages are 16 KB, so the low 14 address bits are the page offset and the upper 26 bits form the virtual page number. The low 8 bits of that page number select one of 256 sets. The remaining 18 bits are the tag, and the tag is compared against both ways of the set in parallel. Each entry holds a tag, a 22-bit physical page number, valid, dirty and use status bits, and two permission bits. One permission bit allows writes. The other allows user-mode access.

The CPU offers a lookup on a valid/ready port, together with a write flag and a user flag. An accepted lookup produces exactly one response one clock later. The response carries a hit flag, a protection-fault flag and the physical address. There is no back-pressure on the response side, so the consumer must take it in the cycle it appears. The lookup port is held off (ready low) in any cycle in which the external miss handler writes an entry through the refill strobe. The refill picks a victim way and installs the new translation. One cycle later it returns the victim's former status bits and page number, so the handler can write them back.

Top module: `sa_xlate_tlb`

## Requirements
- R1: After reset every entry is invalid. The outputs rsp_valid, rsp_hit, rsp_fault and fill_done are low, and req_ready is high while no refill is requested.
- R2: A lookup is accepted when req_valid and req_ready are both high at a clock edge. rsp_valid is high for exactly the one cycle that follows each accepted lookup and is low otherwise.
- R3: A lookup hits when one way of the set selected by vaddr[21:14] is valid and its tag equals vaddr[39:22]. If the access is permitted, rsp_hit is 1 and rsp_paddr is {stored page number, vaddr[13:0]}.
- R4: A lookup that matches no valid way returns rsp_hit=0 and rsp_fault=0, and rsp_paddr holds zero in bits [35:14] and the page offset in bits [13:0].
- R5: A matching lookup faults when it is a write to an entry whose write permission is 0, or a user access to an entry whose user permission is 0. A faulting lookup returns rsp_fault=1, rsp_hit=0 and a zero page number. Supervisor reads of a valid matching entry never fault.
- R6: A permitted read hit sets the entry's use bit. A permitted write hit sets its dirty bit. A faulting access changes neither bit.
- R7: A refill replaces the lowest-numbered invalid way of the set. If both ways are valid, it replaces the way that was not the most recent to be hit or refilled.
- R8: A refill installs a valid entry with dirty=0 and use=0 and the supplied permissions. One cycle later fill_done pulses, and vic_valid, vic_dirty, vic_used and vic_vpn report the replaced entry as it stood before the refill.
- R9: While fill_en is high, req_ready is low and no lookup is accepted.
- R10: Permission bits change only through refill. Repeated lookups, including faulting ones, never alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | 40 | Virtual byte address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_valid | output | 1 | Response for the lookup accepted one cycle earlier |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_fault | output | 1 | Protection violation |
| rsp_paddr | output | 36 | Physical byte address |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | 26 | Virtual page number to install |
| fill_ppn | input | 22 | Physical page number to install |
| fill_wr_ok | input | 1 | Write permission of the new entry |
| fill_usr_ok | input | 1 | User permission of the new entry |
| fill_done | output | 1 | Victim report valid (one cycle after fill_en) |
| vic_valid | output | 1 | Victim was valid |
| vic_dirty | output | 1 | Victim dirty bit |
| vic_used | output | 1 | Victim use bit |
| vic_vpn | output | 26 | Victim virtual page number |

## Verification
The assertions assume the miss handler never installs a page number that is already resident. Under that condition at most one way can match. The bench keeps a model of every set and refills a page only when the model shows it absent; otherwise it turns that step into a lookup. Random traffic is confined to four sets and six tags, including the top set and the all-ones tag. This forces hits, evictions and both replacement choices, and directed steps cover faults, victim status readback and a refill that collides with a lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int unsigned VA_W  = 40;
  parameter int unsigned PA_W  = 36;
  parameter int unsigned OFS_W = 14;
  parameter int unsigned IDX_W = 8;
  localparam int unsigned VPN_W = VA_W - OFS_W;
  localparam int unsigned TAG_W = VPN_W - IDX_W;
  localparam int unsigned PPN_W = PA_W - OFS_W;
  localparam int unsigned WAYS  = 2;
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned SETS  = 1 << IDX_W;

  typedef struct packed {
    logic             valid;
    logic             dirty;
    logic             used;
    logic             wr_ok;
    logic             usr_ok;
    logic [TAG_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_set,
  output tlb_entry_t       rd_entry,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_set,
  input  tlb_entry_t       wr_entry
);
  tlb_entry_t mem [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SETS); i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_set] <= wr_entry;
    end
  end

  assign rd_entry = mem[rd_set];
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  tlb_entry_t [WAYS-1:0]  ent,
  input  logic [TAG_W-1:0]       tag,
  input  logic                   is_write,
  input  logic                   is_user,
  output logic                   tag_hit,
  output logic [WAY_W-1:0]       hit_way,
  output tlb_entry_t             sel,
  output logic                   perm_fault
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = ent[w].valid && (ent[w].tag == tag);
  end

  always_comb begin
    tag_hit = |match;
    hit_way = '0;
    sel     = ent[0];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit_way = WAY_W'(w);
        sel     = ent[w];
      end
    end
    perm_fault = tag_hit && ((is_write && !sel.wr_ok) || (is_user && !sel.usr_ok));
  end

  // R3
  one_way_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R5
  fault_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_fault |-> tag_hit);
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_set,
  input  logic [WAYS-1:0]  way_valid,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way
);
  logic [WAY_W-1:0] mru [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SETS); i++) mru[i] <= '0;
    end else if (touch_en) begin
      mru[touch_set] <= touch_way;
    end
  end

  always_comb begin
    victim = ~mru[rd_set];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) victim = WAY_W'(w);
    end
  end

  // R7
  victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&way_valid) |-> !way_valid[victim]);

  // R7
  mru_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> mru[$past(touch_set)] == $past(touch_way));
endmodule

// File: rtl/sa_xlate_tlb.sv
module sa_xlate_tlb
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr_ok,
  input  logic             fill_usr_ok,
  output logic             fill_done,
  output logic             vic_valid,
  output logic             vic_dirty,
  output logic             vic_used,
  output logic [VPN_W-1:0] vic_vpn
);
  logic [VPN_W-1:0]     lk_vpn;
  logic [IDX_W-1:0]     lk_set;
  logic [TAG_W-1:0]     lk_tag;
  logic [IDX_W-1:0]     act_set;
  logic                 accept;
  tlb_entry_t [WAYS-1:0] rd_ent;
  logic [WAYS-1:0]      way_valid;
  logic [WAYS-1:0]      way_wr;
  logic                 tag_hit;
  logic [WAY_W-1:0]     hit_way;
  tlb_entry_t           sel;
  logic                 perm_fault;
  logic                 hit_ok;
  logic [WAY_W-1:0]     victim;
  tlb_entry_t           upd_ent;
  tlb_entry_t           new_ent;
  tlb_entry_t           wr_ent;

  assign req_ready = !fill_en;
  assign accept    = req_valid && req_ready;
  assign lk_vpn    = req_vaddr[VA_W-1:OFS_W];
  assign lk_set    = lk_vpn[IDX_W-1:0];
  assign lk_tag    = lk_vpn[VPN_W-1:IDX_W];
  assign act_set   = fill_en ? fill_vpn[IDX_W-1:0] : lk_set;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_valid[w] = rd_ent[w].valid;
    assign way_wr[w]    = fill_en ? (victim == WAY_W'(w))
                                  : (hit_ok && hit_way == WAY_W'(w));
    tlb_way_store u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (act_set),
      .rd_entry (rd_ent[w]),
      .wr_en    (way_wr[w]),
      .wr_set   (act_set),
      .wr_entry (wr_ent)
    );
  end

  tlb_match u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent        (rd_ent),
    .tag        (lk_tag),
    .is_write   (req_write),
    .is_user    (req_user),
    .tag_hit    (tag_hit),
    .hit_way    (hit_way),
    .sel        (sel),
    .perm_fault (perm_fault)
  );

  assign hit_ok = accept && tag_hit && !perm_fault;

  tlb_repl u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set    (act_set),
    .way_valid (way_valid),
    .victim    (victim),
    .touch_en  (fill_en || hit_ok),
    .touch_set (act_set),
    .touch_way (fill_en ? victim : hit_way)
  );

  always_comb begin
    upd_ent = sel;
    if (req_write) upd_ent.dirty = 1'b1;
    else           upd_ent.used  = 1'b1;
    new_ent        = '0;
    new_ent.valid  = 1'b1;
    new_ent.wr_ok  = fill_wr_ok;
    new_ent.usr_ok = fill_usr_ok;
    new_ent.tag    = fill_vpn[VPN_W-1:IDX_W];
    new_ent.ppn    = fill_ppn;
    wr_ent         = fill_en ? new_ent : upd_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      fill_done <= 1'b0;
      vic_valid <= 1'b0;
      vic_dirty <= 1'b0;
      vic_used  <= 1'b0;
      vic_vpn   <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_hit   <= hit_ok;
      rsp_fault <= accept && perm_fault;
      if (accept) begin
        rsp_paddr <= {(hit_ok ? sel.ppn : {PPN_W{1'b0}}), req_vaddr[OFS_W-1:0]};
      end
      fill_done <= fill_en;
      if (fill_en) begin
        vic_valid <= rd_ent[victim].valid;
        vic_dirty <= rd_ent[victim].dirty;
        vic_used  <= rd_ent[victim].used;
        vic_vpn   <= {rd_ent[victim].tag, act_set};
      end
    end
  end

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R2
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);

  // R3
  ofs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]));

  // R5
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  // R4
  quiet_without_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit && !rsp_fault);

  // R9
  fill_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !req_ready);

  // R8
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> fill_done);
endmodule

// File: tb/tb_sa_xlate_tlb.sv
module tb_sa_xlate_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [35:0] rsp_paddr;
  logic        fill_en = 1'b0;
  logic [25:0] fill_vpn = '0;
  logic [21:0] fill_ppn = '0;
  logic        fill_wr_ok = 1'b0;
  logic        fill_usr_ok = 1'b0;
  logic        fill_done, vic_valid, vic_dirty, vic_used;
  logic [25:0] vic_vpn;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  bit         m_v   [256][2];
  bit         m_d   [256][2];
  bit         m_u   [256][2];
  bit         m_w   [256][2];
  bit         m_us  [256][2];
  bit [17:0]  m_tag [256][2];
  bit [21:0]  m_ppn [256][2];
  bit         m_mru [256];

  always #10 clk = ~clk;

  sa_xlate_tlb dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_wr_ok(fill_wr_ok), .fill_usr_ok(fill_usr_ok),
    .fill_done(fill_done), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
    .vic_used(vic_used), .vic_vpn(vic_vpn)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int find_way(input bit [25:0] vpn);
    int s = int'(vpn[7:0]);
    find_way = -1;
    for (int i = 0; i < 2; i++) if (m_v[s][i] && m_tag[s][i] == vpn[25:8]) find_way = i;
  endfunction

  // Lookup at the current falling edge; response checked at the next one.
  task automatic lookup(input bit [25:0] vpn, input bit [13:0] ofs, input bit wr, input bit usr);
    int s = int'(vpn[7:0]);
    int w = find_way(vpn);
    bit e_hit = 1'b0, e_flt = 1'b0;
    bit [35:0] e_pa = {22'd0, ofs};
    if (w >= 0) begin
      e_flt = (wr && !m_w[s][w]) || (usr && !m_us[s][w]);
      e_hit = !e_flt;
      if (e_hit) e_pa = {m_ppn[s][w], ofs};
    end
    req_valid = 1'b1; req_vaddr = {vpn, ofs}; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(w >= 0 ? "R3" : "R4", "rsp_hit", 64'(rsp_hit), 64'(e_hit));
    chk("R5", "rsp_fault", 64'(rsp_fault), 64'(e_flt));
    chk(e_hit ? "R3" : "R4", "rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
    if (e_hit) begin
      if (wr) m_d[s][w] = 1'b1; else m_u[s][w] = 1'b1;
      m_mru[s] = w[0];
    end
  endtask

  // Refill, optionally colliding with a lookup request (R9).
  task automatic fill(input bit [25:0] vpn, input bit [21:0] ppn, input bit wok, input bit uok, input bit with_req);
    int s = int'(vpn[7:0]);
    int vic = !m_v[s][0] ? 0 : (!m_v[s][1] ? 1 : int'(!m_mru[s]));
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_wr_ok = wok; fill_usr_ok = uok;
    if (with_req) begin
      req_valid = 1'b1; req_vaddr = {vpn ^ 26'h1, 14'h5}; req_write = 1'b0; req_user = 1'b0;
      #1 chk("R9", "req_ready during refill", 64'(req_ready), 64'd0);
    end
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    if (with_req) chk("R9", "rsp_valid after blocked lookup", 64'(rsp_valid), 64'd0);
    chk("R8", "fill_done", 64'(fill_done), 64'd1);
    chk("R7", "vic_valid", 64'(vic_valid), 64'(m_v[s][vic]));
    if (m_v[s][vic]) begin
      chk("R7", "vic_vpn", 64'(vic_vpn), 64'({m_tag[s][vic], vpn[7:0]}));
      chk("R6", "vic_dirty", 64'(vic_dirty), 64'(m_d[s][vic]));
      chk("R6", "vic_used", 64'(vic_used), 64'(m_u[s][vic]));
    end
    m_v[s][vic] = 1'b1; m_d[s][vic] = 1'b0; m_u[s][vic] = 1'b0;
    m_w[s][vic] = wok; m_us[s][vic] = uok;
    m_tag[s][vic] = vpn[25:8]; m_ppn[s][vic] = ppn;
    m_mru[s] = vic[0];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam bit [25:0] PX = {18'h00012, 8'h40};
  localparam bit [25:0] PY = {18'h3FFFF, 8'h40};
  localparam bit [25:0] PZ = {18'h00777, 8'h40};
  localparam bit [25:0] PW = {18'h00001, 8'h40};

  initial begin
    bit [7:0]  sets [4];
    bit [17:0] tags [6];
    sets = '{8'h00, 8'h01, 8'h7E, 8'hFF};
    tags = '{18'h0, 18'h1, 18'h2, 18'h155, 18'h2AAA, 18'h3FFFF};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1", "fill_done in reset", 64'(fill_done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready idle", 64'(req_ready), 64'd1);
    chk("R1", "rsp_hit idle", 64'(rsp_hit), 64'd0);
    lookup(PX, 14'h1234, 1'b0, 1'b1);              // R1 R4: empty array misses
    fill(PX, 22'h2ABCD, 1'b1, 1'b1, 1'b0);         // R8: fills free way 0
    lookup(PX, 14'h3FFF, 1'b0, 1'b1);              // R3 R6: user read hit sets use
    fill(PY, 22'h00F0F, 1'b0, 1'b0, 1'b0);         // R7: free way 1
    lookup(PY, 14'h0001, 1'b0, 1'b1);              // R5: user denied
    lookup(PY, 14'h0002, 1'b1, 1'b0);              // R5 R10: write denied
    lookup(PY, 14'h0002, 1'b1, 1'b0);              // R10: still denied
    lookup(PY, 14'h0003, 1'b0, 1'b0);              // R5: supervisor read allowed
    lookup(PX, 14'h0000, 1'b1, 1'b1);              // R6: write hit sets dirty
    fill(PZ, 22'h11111, 1'b1, 1'b0, 1'b0);         // R6 R7: evicts PY, clean and used
    fill(PW, 22'h22222, 1'b1, 1'b1, 1'b0);         // R6 R7: evicts PX, dirty and used
    lookup(PX, 14'h0AAA, 1'b0, 1'b0);              // R4: evicted page misses
    fill(PX, 22'h33333, 1'b1, 1'b1, 1'b1);         // R9: collision with lookup
    @(negedge clk);
    chk("R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    for (int i = 0; i < 4000; i++) begin
      bit [25:0] vpn = {tags[$urandom % 6], sets[$urandom % 4]};
      if (($urandom % 3) == 0 && find_way(vpn) < 0)
        fill(vpn, 22'($urandom), 1'($urandom), 1'($urandom), 1'(($urandom % 8) == 0));
      else
        lookup(vpn, 14'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule